// File: doc/BRIEF.md
# Dual-Line Vectored Interrupt Controller

This block collects level-sensitive interrupt requests from a set of sources and merges them onto two exception lines for a processor core: a normal interrupt line and a fast interrupt line. The sources are one dedicated high-priority pin, sixteen active-low external inputs, two timer requests, a parameterised group of peripheral requests and two requests from inside the processor. For each source, software sets an enable bit and a steering bit. The steering bit picks which of the two lines the source drives.

Software works with the block through a small register bus. Through it software reads and writes the enable, steering, vector base and endpoint-output registers. It can also read the raw request levels, the levels after masking, and one vector register for each line. A vector register returns the handler address of the winning pending source on its line. The winner is the lowest source index, and the high-priority pin holds index 0. In endpoint mode, external inputs 0 to 3 no longer act as requests, and four active-low outputs are driven from a software register instead.

Top module: `dvic`

## Requirements
- R1: A source contributes to a line only while its enable bit (register 0, bit = source index, 1 = enabled) is set. The masked view (register 3) reads raw AND enable, and it resets to all zeros.
- R2: Steering bit = 1 (register 1) sends the source to the fast line only. Steering bit = 0 sends it to the normal line only.
- R3: A line output is registered. It rises one clock edge after an enabled source steered to it becomes active at the block, and it falls one edge after the last such source drops.
- R4: Requests are level sensitive and nothing is latched. When no source is active, both lines are low one edge later and the raw view (register 2) reads 0.
- R5: Fixed priority on each line: the lowest active source index wins. The index map is 0 = high-priority pin, 1..16 = external inputs 0..15, 17..18 = timers, 19..22 = peripherals, 23..24 = processor sources.
- R6: Vector registers (4 = normal line, 5 = fast line) return base + index*32 for the winner, or the code 0x00000001 when nothing is pending on that line.
- R7: The high-priority pin and the external inputs are active low and pass through a two-flop synchronizer. A line therefore rises on the third edge after such a pin falls.
- R8: While the endpoint mode input is 1, external inputs 0..3 are ignored, and output bit k is low exactly when bit k of register 7 is set. With the mode at 0, all four outputs sit high.
- R9: The vector base (register 6) is writable, and its low five bits always read 0. Enable and steering read back as written.
- R10: After reset both lines are low, the enable and steering registers are 0, the endpoint outputs are high, and both vectors read 0x00000001.
- R11: A read issued on one edge presents its data with the valid flag during the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ep_mode_i | input | 1 | Endpoint mode select |
| hpi_n_i | input | 1 | High-priority request pin, active low |
| xin_n_i | input | 16 | External request inputs, active low |
| tmr_i | input | 2 | Timer requests, active high |
| per_i | input | NPER | Peripheral requests, active high |
| cpu_i | input | 2 | Processor-internal requests, active high |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| bus_rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| intout_n_o | output | 4 | Endpoint interrupt outputs, active low |

## Verification
Internal requests reach a line one edge after they change, and external pins reach it on the third edge. Register reads return one edge after the strobe, and the endpoint outputs follow their register and the mode input with no extra delay. The bench drives every input on the falling edge and checks each line result only after counting the edges that requirement gives. For the synchronized pins it checks the two quiet cycles before the rise as well as the rise itself. Read results are pushed into a scoreboard queue when each read is issued, and they are popped on the falling edge where the valid flag is seen, so every read value is compared in the exact cycle it is due.

// File: rtl/dvic_pkg.sv
package dvic_pkg;
  localparam int VEC_SHIFT = 5;
  localparam logic [31:0] NO_VEC = 32'h0000_0001;

  typedef enum logic [2:0] {
    A_EN     = 3'd0,
    A_STEER  = 3'd1,
    A_RAW    = 3'd2,
    A_MASKED = 3'd3,
    A_IVEC   = 3'd4,
    A_FVEC   = 3'd5,
    A_BASE   = 3'd6,
    A_EPOUT  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/dvic_sync.sv
module dvic_sync #(
  parameter int W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st1_q, st2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st1_q <= '1;
      st2_q <= '1;
    end else begin
      st1_q <= d_i;
      st2_q <= st1_q;
    end
  end

  assign q_o = st2_q;
endmodule

// File: rtl/dvic_pick.sv
module dvic_pick #(
  parameter int N  = 25,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] below;

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  assign below = (N'(1) << idx_o) - N'(1);

  // R5: the winner is pending and no lower index is pending
  p_winner_lowest_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (req_i[idx_o] && ((req_i & below) == '0)));

  // R6: "nothing pending" only when the request vector is empty
  p_empty_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (req_i == '0));
endmodule

// File: rtl/dvic.sv
module dvic
  import dvic_pkg::*;
#(
  parameter int NPER = 4,
  parameter int NEXT = 16,
  parameter int NEP  = 4,
  parameter int DW   = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ep_mode_i,
  input  logic            hpi_n_i,
  input  logic [NEXT-1:0] xin_n_i,
  input  logic [1:0]      tmr_i,
  input  logic [NPER-1:0] per_i,
  input  logic [1:0]      cpu_i,
  input  logic            bus_wr_i,
  input  logic            bus_rd_i,
  input  logic [2:0]      bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            bus_rvalid_o,
  output logic            irq_o,
  output logic            fiq_o,
  output logic [NEP-1:0]  intout_n_o
);
  localparam int NSRC = 1 + NEXT + 2 + NPER + 2;
  localparam int IW   = $clog2(NSRC);
  localparam int XB   = 1;
  localparam int TB   = XB + NEXT;
  localparam int PB   = TB + 2;
  localparam int CB   = PB + NPER;
  localparam int PADW = DW - NSRC;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  // synchronize active-low pins
  logic [NEXT:0] pin_s;
  dvic_sync #(.W(NEXT + 1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_q),
    .d_i   ({xin_n_i, hpi_n_i}),
    .q_o   (pin_s)
  );

  logic [NSRC-1:0] raw, masked, irq_req, fiq_req;
  always_comb begin
    raw     = '0;
    raw[0]  = ~pin_s[0];
    for (int i = 0; i < NEXT; i++)
      raw[XB+i] = ~pin_s[1+i] & ~(ep_mode_i && (i < NEP));
    raw[TB +: 2]    = tmr_i;
    raw[PB +: NPER] = per_i;
    raw[CB +: 2]    = cpu_i;
  end

  // state
  logic [NSRC-1:0] en_q, en_d, steer_q, steer_d;
  logic [DW-1:0]   base_q, base_d, rdata_q, rdata_d;
  logic [NEP-1:0]  epo_q, epo_d;
  logic            rvalid_d, irq_d, fiq_d, irq_q, fiq_q;

  assign masked  = raw & en_q;
  assign irq_req = masked & ~steer_q;
  assign fiq_req = masked & steer_q;

  logic          ivld, fvld;
  logic [IW-1:0] iidx, fidx;
  dvic_pick #(.N(NSRC), .IW(IW)) u_pick_irq (
    .clk_i(clk_i), .rst_ni(rst_q), .req_i(irq_req), .valid_o(ivld), .idx_o(iidx));
  dvic_pick #(.N(NSRC), .IW(IW)) u_pick_fiq (
    .clk_i(clk_i), .rst_ni(rst_q), .req_i(fiq_req), .valid_o(fvld), .idx_o(fidx));

  logic [DW-1:0] ivec, fvec;
  assign ivec = ivld ? base_q + (DW'(iidx) << VEC_SHIFT) : DW'(NO_VEC);
  assign fvec = fvld ? base_q + (DW'(fidx) << VEC_SHIFT) : DW'(NO_VEC);

  // next state
  always_comb begin
    en_d     = en_q;
    steer_d  = steer_q;
    base_d   = base_q;
    epo_d    = epo_q;
    rdata_d  = rdata_q;
    rvalid_d = bus_rd_i;
    irq_d    = |irq_req;
    fiq_d    = |fiq_req;
    if (bus_wr_i) begin
      unique case (reg_addr_e'(bus_addr_i))
        A_EN:    en_d    = bus_wdata_i[NSRC-1:0];
        A_STEER: steer_d = bus_wdata_i[NSRC-1:0];
        A_BASE:  base_d  = bus_wdata_i & ~DW'((1 << VEC_SHIFT) - 1);
        A_EPOUT: epo_d   = bus_wdata_i[NEP-1:0];
        default: ;
      endcase
    end
    if (bus_rd_i) begin
      unique case (reg_addr_e'(bus_addr_i))
        A_EN:     rdata_d = {{PADW{1'b0}}, en_q};
        A_STEER:  rdata_d = {{PADW{1'b0}}, steer_q};
        A_RAW:    rdata_d = {{PADW{1'b0}}, raw};
        A_MASKED: rdata_d = {{PADW{1'b0}}, masked};
        A_IVEC:   rdata_d = ivec;
        A_FVEC:   rdata_d = fvec;
        A_BASE:   rdata_d = base_q;
        A_EPOUT:  rdata_d = {{(DW-NEP){1'b0}}, epo_q};
        default:  rdata_d = '0;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q) begin
      en_q    <= '0;
      steer_q <= '0;
      base_q  <= '0;
      epo_q   <= '0;
      rdata_q <= '0;
      rvalid_q_r <= 1'b0;
      irq_q   <= 1'b0;
      fiq_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      steer_q <= steer_d;
      base_q  <= base_d;
      epo_q   <= epo_d;
      if (bus_rd_i) rdata_q <= rdata_d;
      rvalid_q_r <= rvalid_d;
      irq_q   <= irq_d;
      fiq_q   <= fiq_d;
    end
  end

  logic rvalid_q_r;
  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q_r;
  assign irq_o        = irq_q;
  assign fiq_o        = fiq_q;
  assign intout_n_o   = ep_mode_i ? ~epo_q : '1;

  // R1: with every source disabled, both lines stay low
  p_quiet_masked_r1: assert property (@(posedge clk_i) disable iff (!rst_q)
    (en_q == '0) |=> (!irq_o && !fiq_o));

  // R2: the fast line needs an enabled source steered to it
  p_fiq_needs_steer_r2: assert property (@(posedge clk_i) disable iff (!rst_q)
    ((fiq_req == '0) && !fvld) |=> !fiq_o);

  // R4: no raw request means both lines low one edge later
  p_idle_after_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_q)
    (raw == '0) |=> (!irq_o && !fiq_o));

  // R6: a vector read is either aligned to the stride or the empty code
  p_vec_shape_r6: assert property (@(posedge clk_i) disable iff (!rst_q)
    (bus_rd_i && (bus_addr_i == A_IVEC || bus_addr_i == A_FVEC)) |=>
      (bus_rdata_o[VEC_SHIFT-1:0] == '0 || bus_rdata_o == DW'(NO_VEC)));

  // R8: outside endpoint mode the outputs are idle
  p_ep_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_q)
    !ep_mode_i |-> (intout_n_o == '1));

  // R11: valid follows a read strobe by one edge
  p_rvalid_r11: assert property (@(posedge clk_i) disable iff (!rst_q)
    bus_rd_i |=> bus_rvalid_o);
endmodule

// File: tb/dvic_bench.sv
module dvic_bench;
  localparam int NPER = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ep_mode = 1'b0, hpi_n = 1'b1;
  logic [15:0] xin_n = '1;
  logic [1:0]  tmr = '0, cpu = '0;
  logic [NPER-1:0] per = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, irq, fiq;
  logic [3:0]  intout_n;

  always #5 clk = ~clk;

  dvic #(.NPER(NPER)) u_dvic (
    .clk_i(clk), .rst_ni(rst_n), .ep_mode_i(ep_mode), .hpi_n_i(hpi_n),
    .xin_n_i(xin_n), .tmr_i(tmr), .per_i(per), .cpu_i(cpu),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .irq_o(irq), .fiq_o(fiq),
    .intout_n_o(intout_n));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string       sb_tag[$];
  logic [31:0] sb_exp[$];
  logic [31:0] base = 32'h1000_0000;

  function automatic logic [31:0] vexp(int idx);
    return base + 32'(idx) * 32;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick(1);
    wr = 1'b0;
  endtask

  // driver: push expectation, issue read
  task automatic bus_read(logic [2:0] a, logic [31:0] exp, string tag);
    sb_tag.push_back(tag);
    sb_exp.push_back(exp);
    rd = 1'b1; addr = a;
    tick(1);
    rd = 1'b0;
  endtask

  // monitor: compare read data when it appears
  always @(negedge clk) begin
    if (rvalid) begin
      if (sb_exp.size() == 0) begin
        check("R11 unexpected rvalid", 32'(rvalid), 32'd0);
      end else begin
        string t;
        logic [31:0] e;
        t = sb_tag.pop_front();
        e = sb_exp.pop_front();
        check(t, rdata, e);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R10 reset state
    check("R10 irq", 32'(irq), 0);
    check("R10 fiq", 32'(fiq), 0);
    check("R10 intout", 32'(intout_n), 32'hF);
    bus_read(3'd0, 32'h0, "R10 enable");
    bus_read(3'd1, 32'h0, "R10 steer");
    bus_read(3'd4, 32'h1, "R10 irq vector");
    bus_read(3'd5, 32'h1, "R10 fiq vector");
    // R9 base and readback
    bus_write(3'd6, 32'h1000_0013);
    bus_read(3'd6, 32'h1000_0000, "R9 base low bits");
    bus_write(3'd0, 32'h01FF_FFFF);
    bus_read(3'd0, 32'h01FF_FFFF, "R9 enable readback");
    // R3 internal source, one edge
    cpu[1] = 1'b1;
    check("R3 irq before edge", 32'(irq), 0);
    tick(1);
    check("R3 irq after edge", 32'(irq), 1);
    bus_read(3'd4, vexp(24), "R6 irq vector idx24");
    // R5 lower index wins
    tmr[0] = 1'b1;
    tick(1);
    bus_read(3'd4, vexp(17), "R5 irq vector idx17");
    // R2 steering
    bus_write(3'd1, 32'h0002_0000);
    tick(1);
    check("R2 fiq", 32'(fiq), 1);
    check("R2 irq", 32'(irq), 1);
    bus_read(3'd5, vexp(17), "R2 fiq vector");
    bus_read(3'd4, vexp(24), "R2 irq vector");
    bus_read(3'd1, 32'h0002_0000, "R9 steer readback");
    // R4 drop
    cpu = '0; tmr = '0;
    tick(1);
    check("R4 irq low", 32'(irq), 0);
    check("R4 fiq low", 32'(fiq), 0);
    bus_read(3'd2, 32'h0, "R4 raw empty");
    bus_read(3'd4, 32'h1, "R6 irq empty code");
    // R1 masking
    bus_write(3'd0, 32'h01F7_FFFF);
    per[0] = 1'b1;
    tick(2);
    check("R1 irq masked", 32'(irq), 0);
    bus_read(3'd2, 32'h0008_0000, "R1 raw shows source");
    bus_read(3'd3, 32'h0, "R1 masked view");
    per[0] = 1'b0;
    bus_write(3'd0, 32'h01FF_FFFF);
    // R7 synchronized pin
    xin_n[5] = 1'b0;
    tick(1); check("R7 edge1", 32'(irq), 0);
    tick(1); check("R7 edge2", 32'(irq), 0);
    tick(1); check("R7 edge3", 32'(irq), 1);
    bus_read(3'd4, vexp(6), "R7 irq vector idx6");
    hpi_n = 1'b0;
    tick(3);
    bus_read(3'd4, vexp(0), "R5 high-priority pin wins");
    // R8 endpoint mode
    hpi_n = 1'b1; xin_n = '1;
    tick(3);
    ep_mode = 1'b1; xin_n[2] = 1'b0;
    tick(4);
    check("R8 irq ignored", 32'(irq), 0);
    bus_read(3'd2, 32'h0, "R8 raw ignored");
    check("R8 intout idle reg", 32'(intout_n), 32'hF);
    bus_write(3'd7, 32'h5);
    check("R8 intout driven", 32'(intout_n), 32'hA);
    ep_mode = 1'b0;
    #1;
    check("R8 intout off", 32'(intout_n), 32'hF);
    tick(1);
    check("R8 input restored", 32'(irq), 1);
    bus_read(3'd2, 32'h0000_0008, "R8 raw restored");
    xin_n = '1;
    tick(5);
    while (sb_exp.size() != 0) tick(1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule